// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block picks the two source operands of the instruction in the execute stage of a five-stage in-order pipeline. Each operand can take the value read from the register file, the result held in the execute/memory pipeline register, or the final value in the memory/writeback register. The choice is made by comparing the operand's source register number with the destination number and write enable of each of the two later stages. When both later stages match, the newer result wins. Register zero is never forwarded.

The block also contains the register file that the decode stage reads. The writeback stage writes it. A decode read of the register being written in the same cycle returns the incoming data. The two outputs per operand are a 2-bit select code, which is useful for observing the mux, and the selected operand value. The two operands follow identical rules and are evaluated independently.

Top module: `opfwd_unit`

## Requirements
- R1: When `exm_we` is 1, `exm_rd` is not 0 and `exm_rd` equals an operand's source number, that operand's select is 2'b10 and its value equals `exm_result`.
- R2: When `mwb_we` is 1, `mwb_rd` is not 0, `mwb_rd` equals an operand's source number and the R1 condition does not hold for that operand, the select is 2'b01 and the value equals `mwb_result`.
- R3: When both later stages match the same operand, the select is 2'b10 and the value is `exm_result`.
- R4: A source number of 0 never forwards. Its select is 2'b00 and its value is the register-read input, even when a later stage writes with destination 0.
- R5: A stage whose write enable is 0 never forwards, whatever its destination number. With neither path active, the select is 2'b00 and the value is the register-read input (`ex_rf_a` / `ex_rf_b`).
- R6: Operand A depends only on `ex_rs_a` and `ex_rf_a`, and operand B depends only on `ex_rs_b` and `ex_rf_b`, together with the shared stage inputs. The two can take different sources in the same cycle.
- R7: A decode read of register r (r not 0), made while `mwb_we` is 1 and `mwb_rd` equals r, returns `mwb_result` in that same cycle, not the stored value.
- R8: Register 0 always reads as zero. A write to it is discarded.
- R9: Reset clears every register to zero. A write made with `mwb_we` at 1 is stored at the rising clock edge and read back on later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register file writes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, clears the register file |
| dec_rs_a | input | 5 | Decode-stage read address, port A |
| dec_rs_b | input | 5 | Decode-stage read address, port B |
| dec_rdata_a | output | 32 | Decode read data A, with same-cycle write bypass |
| dec_rdata_b | output | 32 | Decode read data B, with same-cycle write bypass |
| ex_rs_a | input | 5 | Source register number of operand A in execute |
| ex_rs_b | input | 5 | Source register number of operand B in execute |
| ex_rf_a | input | 32 | Register-read value of operand A carried into execute |
| ex_rf_b | input | 32 | Register-read value of operand B carried into execute |
| exm_we | input | 1 | Execute/memory stage writes a register |
| exm_rd | input | 5 | Execute/memory stage destination number |
| exm_result | input | 32 | Result held in the execute/memory register |
| mwb_we | input | 1 | Memory/writeback stage writes a register |
| mwb_rd | input | 5 | Memory/writeback stage destination number |
| mwb_result | input | 32 | Final value in the memory/writeback register, also the write data |
| sel_a | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 writeback |
| sel_b | output | 2 | Operand B select, same encoding |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The assertions sample the combinational outputs at each rising edge. They assume that the inputs are settled by then and do not change at the edge. The bench meets this by driving every input on the falling edge only. The properties also assume known values on the stage inputs from reset onward. The bench therefore drives every input to zero at time zero, before reset is released, and each scenario task holds all the fields it does not use at defined values.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WBACK   = 2'b01,
    SRC_EXMEM   = 2'b10
  } opsrc_e;

  localparam int NUM_OPND = 2;

  function automatic logic stage_hits(input logic we, input logic [7:0] rd,
                                      input logic [7:0] rs);
    return we && (rd != 8'd0) && (rd == rs);
  endfunction

endpackage

// File: rtl/opfwd_regfile.sv
module opfwd_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][XLEN-1:0] rd_data,
  output logic [NRD-1:0]           rd_bypassed
);

  logic [XLEN-1:0] mem [NREGS];
  logic            wr_live;

  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      rd_bypassed[p] = wr_live && (rd_addr[p] == wr_addr);
      if (rd_addr[p] == '0)
        rd_data[p] = '0;
      else if (rd_bypassed[p])
        rd_data[p] = wr_data;
      else
        rd_data[p] = mem[rd_addr[p]];
    end
  end

endmodule

// File: rtl/opfwd_pick.sv
module opfwd_pick
  import opfwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic [AW-1:0]   rs,
  input  logic [XLEN-1:0] rf_val,
  input  logic            exm_we,
  input  logic [AW-1:0]   exm_rd,
  input  logic [XLEN-1:0] exm_val,
  input  logic            mwb_we,
  input  logic [AW-1:0]   mwb_rd,
  input  logic [XLEN-1:0] mwb_val,
  output opsrc_e          sel,
  output logic [XLEN-1:0] val,
  output logic            hit_exm,
  output logic            hit_mwb
);

  assign hit_exm = stage_hits(exm_we, 8'(exm_rd), 8'(rs));
  assign hit_mwb = stage_hits(mwb_we, 8'(mwb_rd), 8'(rs));

  always_comb begin
    if (hit_exm)      sel = SRC_EXMEM;
    else if (hit_mwb) sel = SRC_WBACK;
    else              sel = SRC_REGFILE;
  end

  always_comb begin
    unique case (sel)
      SRC_EXMEM: val = exm_val;
      SRC_WBACK: val = mwb_val;
      default:   val = rf_val;
    endcase
  end

endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   dec_rs_a,
  input  logic [AW-1:0]   dec_rs_b,
  output logic [XLEN-1:0] dec_rdata_a,
  output logic [XLEN-1:0] dec_rdata_b,
  input  logic [AW-1:0]   ex_rs_a,
  input  logic [AW-1:0]   ex_rs_b,
  input  logic [XLEN-1:0] ex_rf_a,
  input  logic [XLEN-1:0] ex_rf_b,
  input  logic            exm_we,
  input  logic [AW-1:0]   exm_rd,
  input  logic [XLEN-1:0] exm_result,
  input  logic            mwb_we,
  input  logic [AW-1:0]   mwb_rd,
  input  logic [XLEN-1:0] mwb_result,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b
);

  logic [NUM_OPND-1:0][AW-1:0]   rs_vec;
  logic [NUM_OPND-1:0][XLEN-1:0] rf_vec;
  logic [NUM_OPND-1:0][XLEN-1:0] val_vec;
  opsrc_e                        sel_vec [NUM_OPND];
  logic [NUM_OPND-1:0]           exm_hit;
  logic [NUM_OPND-1:0]           mwb_hit;
  logic [NUM_OPND-1:0][AW-1:0]   dec_addr;
  logic [NUM_OPND-1:0][XLEN-1:0] dec_data;
  logic [NUM_OPND-1:0]           dec_bypass;

  assign rs_vec   = {ex_rs_b, ex_rs_a};
  assign rf_vec   = {ex_rf_b, ex_rf_a};
  assign dec_addr = {dec_rs_b, dec_rs_a};

  opfwd_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(NUM_OPND)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (mwb_we),
    .wr_addr    (mwb_rd),
    .wr_data    (mwb_result),
    .rd_addr    (dec_addr),
    .rd_data    (dec_data),
    .rd_bypassed(dec_bypass)
  );

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_op
    opfwd_pick #(.XLEN(XLEN), .AW(AW)) u_pick (
      .rs     (rs_vec[k]),
      .rf_val (rf_vec[k]),
      .exm_we (exm_we),
      .exm_rd (exm_rd),
      .exm_val(exm_result),
      .mwb_we (mwb_we),
      .mwb_rd (mwb_rd),
      .mwb_val(mwb_result),
      .sel    (sel_vec[k]),
      .val    (val_vec[k]),
      .hit_exm(exm_hit[k]),
      .hit_mwb(mwb_hit[k])
    );
  end

  logic exm_hit_a, exm_hit_b, mwb_hit_a, mwb_hit_b;
  assign exm_hit_a = exm_hit[0];
  assign exm_hit_b = exm_hit[1];
  assign mwb_hit_a = mwb_hit[0];
  assign mwb_hit_b = mwb_hit[1];

  assign sel_a       = sel_vec[0];
  assign sel_b       = sel_vec[1];
  assign opnd_a      = val_vec[0];
  assign opnd_b      = val_vec[1];
  assign dec_rdata_a = dec_data[0];
  assign dec_rdata_b = dec_data[1];

endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   dec_rs_a,
  input logic [XLEN-1:0] dec_rdata_a,
  input logic [AW-1:0]   ex_rs_a,
  input logic [AW-1:0]   ex_rs_b,
  input logic [XLEN-1:0] ex_rf_a,
  input logic            exm_we,
  input logic [XLEN-1:0] exm_result,
  input logic            mwb_we,
  input logic [AW-1:0]   mwb_rd,
  input logic [XLEN-1:0] mwb_result,
  input logic [1:0]      sel_a,
  input logic [1:0]      sel_b,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic            exm_hit_a,
  input logic            mwb_hit_a
);

  p_exm_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'b10) |-> (opnd_a == exm_result));

  p_wb_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == 2'b01) |-> (opnd_b == mwb_result));

  p_newer_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_hit_a && mwb_hit_a) |-> (opnd_a == exm_result));

  p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs_a == '0) |-> (sel_a == 2'b00 && opnd_a == ex_rf_a));

  p_we_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!exm_we && !mwb_we) |-> (sel_a == 2'b00 && sel_b == 2'b00));

  p_sel_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'b11) && (sel_b != 2'b11));

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mwb_we && mwb_rd != '0 && dec_rs_a == mwb_rd) |-> (dec_rdata_a == mwb_result));

  p_zero_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs_a == '0) |-> (dec_rdata_a == '0));

endmodule

bind opfwd_unit opfwd_unit_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dec_rs_a   (dec_rs_a),
  .dec_rdata_a(dec_rdata_a),
  .ex_rs_a    (ex_rs_a),
  .ex_rs_b    (ex_rs_b),
  .ex_rf_a    (ex_rf_a),
  .exm_we     (exm_we),
  .exm_result (exm_result),
  .mwb_we     (mwb_we),
  .mwb_rd     (mwb_rd),
  .mwb_result (mwb_result),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .exm_hit_a  (exm_hit_a),
  .mwb_hit_a  (mwb_hit_a)
);

// File: tb/opfwd_unit_bench.sv
module opfwd_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  dec_rs_a = '0, dec_rs_b = '0;
  logic [31:0] dec_rdata_a, dec_rdata_b;
  logic [4:0]  ex_rs_a = '0, ex_rs_b = '0;
  logic [31:0] ex_rf_a = '0, ex_rf_b = '0;
  logic        exm_we = 1'b0;
  logic [4:0]  exm_rd = '0;
  logic [31:0] exm_result = '0;
  logic        mwb_we = 1'b0;
  logic [4:0]  mwb_rd = '0;
  logic [31:0] mwb_result = '0;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  opfwd_unit u_opfwd_unit (
    .clk(clk), .rst_n(rst_n),
    .dec_rs_a(dec_rs_a), .dec_rs_b(dec_rs_b),
    .dec_rdata_a(dec_rdata_a), .dec_rdata_b(dec_rdata_b),
    .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b),
    .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .exm_we(exm_we), .exm_rd(exm_rd), .exm_result(exm_result),
    .mwb_we(mwb_we), .mwb_rd(mwb_rd), .mwb_result(mwb_result),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected select code for one operand, written from R1..R5.
  function automatic logic [1:0] exp_sel(input logic [4:0] rs);
    if (rs == 0) return 2'b00;
    if (exm_we && exm_rd == rs) return 2'b10;
    if (mwb_we && mwb_rd == rs) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_val(input logic [4:0] rs, input logic [31:0] rf);
    case (exp_sel(rs))
      2'b10:   return exm_result;
      2'b01:   return mwb_result;
      default: return rf;
    endcase
  endfunction

  task automatic settle(); #2; endtask

  task automatic set_ex(input logic [4:0] ra, input logic [4:0] rb,
                        input logic ew, input logic [4:0] erd,
                        input logic mw, input logic [4:0] mrd);
    @(negedge clk);
    ex_rs_a = ra; ex_rs_b = rb;
    ex_rf_a = 32'hA000_0000 | 32'(ra); ex_rf_b = 32'hB000_0000 | 32'(rb);
    exm_we = ew; exm_rd = erd; exm_result = 32'hE0E0_0000 | 32'(erd);
    mwb_we = mw; mwb_rd = mrd; mwb_result = 32'h5B5B_0000 | 32'(mrd);
    settle();
  endtask

  task automatic idle_stages();
    @(negedge clk);
    exm_we = 1'b0; mwb_we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] r, input logic [31:0] d);
    @(negedge clk);
    exm_we = 1'b0;
    mwb_we = 1'b1; mwb_rd = r; mwb_result = d;
    @(negedge clk);
    mwb_we = 1'b0;
    if (r != 0) model[r] = d;
  endtask

  task automatic t_reset();
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      dec_rs_a = 5'(r); dec_rs_b = 5'(31 - r);
      settle();
      chk($sformatf("R9 reset read a%0d", r), dec_rdata_a, 32'h0);
    end
    set_ex(5'd3, 5'd4, 1'b0, 5'd3, 1'b0, 5'd4);
    chk("R5 reset sel_a", 32'(sel_a), 32'h0);
    chk("R5 reset opnd_b", opnd_b, ex_rf_b);
  endtask

  task automatic t_exm();
    set_ex(5'd5, 5'd6, 1'b1, 5'd5, 1'b0, 5'd0);
    chk("R1 exm sel_a", 32'(sel_a), 32'h2);
    chk("R1 exm opnd_a", opnd_a, exm_result);
    chk("R6 b untouched sel_b", 32'(sel_b), 32'h0);
    chk("R6 b untouched opnd_b", opnd_b, ex_rf_b);
  endtask

  task automatic t_mwb();
    set_ex(5'd7, 5'd12, 1'b1, 5'd8, 1'b1, 5'd12);
    chk("R2 wb sel_b", 32'(sel_b), 32'h1);
    chk("R2 wb opnd_b", opnd_b, mwb_result);
    chk("R2 a no match sel_a", 32'(sel_a), 32'h0);
  endtask

  task automatic t_both();
    set_ex(5'd9, 5'd9, 1'b1, 5'd9, 1'b1, 5'd9);
    mwb_result = 32'h0D0D_0009;
    settle();
    chk("R3 both sel_a", 32'(sel_a), 32'h2);
    chk("R3 both opnd_a", opnd_a, exm_result);
    chk("R3 both opnd_b", opnd_b, exm_result);
  endtask

  task automatic t_zero();
    set_ex(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    ex_rf_a = 32'h1234_5678;
    settle();
    chk("R4 zero sel_a", 32'(sel_a), 32'h0);
    chk("R4 zero opnd_a", opnd_a, 32'h1234_5678);
    chk("R4 zero sel_b", 32'(sel_b), 32'h0);
  endtask

  task automatic t_we_low();
    set_ex(5'd14, 5'd15, 1'b0, 5'd14, 1'b0, 5'd15);
    chk("R5 exm we low sel_a", 32'(sel_a), 32'h0);
    chk("R5 wb we low sel_b", 32'(sel_b), 32'h0);
    chk("R5 we low opnd_a", opnd_a, ex_rf_a);
    set_ex(5'd14, 5'd14, 1'b0, 5'd14, 1'b1, 5'd14);
    chk("R5 exm off falls to wb", 32'(sel_a), 32'h1);
  endtask

  task automatic t_indep();
    set_ex(5'd20, 5'd21, 1'b1, 5'd20, 1'b1, 5'd21);
    chk("R6 split sel_a", 32'(sel_a), 32'h2);
    chk("R6 split sel_b", 32'(sel_b), 32'h1);
    chk("R6 split opnd_b", opnd_b, mwb_result);
    idle_stages();
  endtask

  task automatic t_store();
    wr(5'd10, 32'hCAFE_0010);
    wr(5'd31, 32'hFFFF_0031);
    @(negedge clk);
    dec_rs_a = 5'd10; dec_rs_b = 5'd31;
    settle();
    chk("R9 stored a", dec_rdata_a, 32'hCAFE_0010);
    chk("R9 stored b", dec_rdata_b, 32'hFFFF_0031);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    exm_we = 1'b0;
    mwb_we = 1'b1; mwb_rd = 5'd10; mwb_result = 32'hBEEF_1010;
    dec_rs_a = 5'd10; dec_rs_b = 5'd11;
    settle();
    chk("R7 bypass a", dec_rdata_a, 32'hBEEF_1010);
    chk("R7 other port stale b", dec_rdata_b, model[11]);
    @(negedge clk);
    mwb_we = 1'b0;
    model[10] = 32'hBEEF_1010;
    settle();
    chk("R9 bypassed write kept", dec_rdata_a, 32'hBEEF_1010);
  endtask

  task automatic t_reg0();
    @(negedge clk);
    mwb_we = 1'b1; mwb_rd = 5'd0; mwb_result = 32'hDEAD_0000;
    dec_rs_a = 5'd0; dec_rs_b = 5'd0;
    settle();
    chk("R8 reg0 during write", dec_rdata_a, 32'h0);
    @(negedge clk);
    mwb_we = 1'b0;
    settle();
    chk("R8 reg0 after write", dec_rdata_b, 32'h0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 200; i++) begin
      set_ex(5'(i * 7), 5'(i * 3 + 1), 1'((i >> 1) & 1), 5'(i & 7),
             1'(i & 1), 5'((i >> 2) & 7));
      chk($sformatf("R3 sweep sel_a %0d", i), 32'(sel_a), 32'(exp_sel(ex_rs_a)));
      chk($sformatf("R6 sweep opnd_b %0d", i), opnd_b, exp_val(ex_rs_b, ex_rf_b));
    end
    idle_stages();
  endtask

  initial begin
    for (int r = 0; r < 32; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exm();
    t_mwb();
    t_both();
    t_zero();
    t_we_low();
    t_indep();
    t_store();
    t_bypass();
    t_reg0();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule